// File: doc/BRIEF.md
# Five-Pin Bidirectional GPIO Port

This block is a small general-purpose I/O port with five pins, attached to a simple memory-mapped register bus. Software programs a per-pin direction register and a port data latch. Together these produce the output-enable and output-value signals for each pad. The same bus reads back either the latched value or the synchronized pin level, chosen per pin.

A separate option register holds two port-wide controls: a pullup enable and an LED drive-mode select. The pullup reaches a pad only while that pad is an input. The LED select is exported unchanged for the pad ring to use.

The data latch has no reset. Its contents therefore survive a reset, and software can load the data before it makes a pin an output. Because the latch always drives the pad's output value, a pin that changes from input to output drives the preloaded level on the first cycle, with no glitch.

Top module: `gpio5_port`

## Requirements
- R1: While reset is asserted at a clock edge, every direction bit clears: `pin_oe` reads 0x00 and the direction register reads back 0x00.
- R2: A write to address 0x06 loads bits 4:0 of the write data into the direction register at that edge, and `pin_oe` follows. A direction bit of 1 makes its pin an output. Reading address 0x06 returns the five direction bits, with bits 7:5 equal to 0.
- R3: A write to address 0x02 loads bits 4:0 into the data latch at that edge, whatever the pin directions are. `pin_out` shows the latch in the next cycle. A pin whose direction bit later goes from 0 to 1 drives the stored value in the same cycle that `pin_oe` rises.
- R4: Reset leaves the data latch unchanged.
- R5: Reading address 0x02 returns, for each of bits 4:0, the latch bit if that pin is an output and the synchronized pin level if it is an input. Bits 7:5 read 0.
- R6: A change on `pin_in` reaches the read-back path after exactly two rising clock edges.
- R7: The option register sits at address 0x0C by default, with bit 0 as the pullup enable and bit 1 as the LED mode. It clears on reset, and its other bits read 0. `pin_pull_en[i]` is 1 only when the pullup enable is 1 and pin i is an input.
- R8: `led_mode` equals option-register bit 1.
- R9: A write to any other address changes no register and no output. A read of any other address returns 0x00.
- R10: Bus writes presented while reset is asserted are ignored, and this includes writes to the data latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for the current access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 5 | Raw pad input levels |
| pin_out | output | 5 | Per-pin output value (the data latch) |
| pin_oe | output | 5 | Per-pin output-buffer enable |
| pin_pull_en | output | 5 | Per-pin pullup enable |
| led_mode | output | 1 | Port-wide LED drive-mode select |

## Verification
Assertions check on every cycle that reset clears the direction bits, that each decoded write lands in the direction, data or option register on the following cycle, and that a pin sample takes exactly two edges to reach the synchronizer output. Other behaviours can only be shown by the bench's scenarios. These include the per-pin mix of latch and pad levels on read-back, the masking of pullups by direction, and the survival of the data latch across a reset. They also include the ignoring of writes during reset and of writes to unmapped addresses, and the glitch-free switch of a preloaded pin to an output.

// File: rtl/gpio5_pkg.sv
// Shared types for the five-pin GPIO port.
// Assumes nothing beyond a single clock domain for the bus side.
package gpio5_pkg;
    // Which register, if any, the current bus address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_OPT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio5_sync.sv
// Multi-stage synchronizer for the raw pad inputs.
// Assumes pin_in is asynchronous to clk; the output is the sample from STAGES edges ago.
module gpio5_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

    // Count edges since reset so the latency check never looks before reset
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R6: output equals the pad level sampled two edges earlier
            p_sync_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (q == $past(d, 2)))
                else $error("p_sync_lat_r6");
        end
    endgenerate
endmodule

// File: rtl/gpio5_regs.sv
// Address decode and register file: data latch (no reset), direction and option.
// Assumes writes are single-cycle strobes; writes during reset are dropped.
module gpio5_regs
    import gpio5_pkg::*;
#(
    parameter int unsigned W         = 5,
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 8,
    parameter logic [AW-1:0] DATA_ADDR = 'h02,
    parameter logic [AW-1:0] DIR_ADDR  = 'h06,
    parameter logic [AW-1:0] OPT_ADDR  = 'h0C,
    parameter int unsigned PULL_BIT  = 0,
    parameter int unsigned LED_BIT   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output reg_sel_e      sel,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q,
    output logic          pull_q,
    output logic          led_q
);
    logic wr_data, wr_dir, wr_opt;

    // Map the address onto one register select
    always_comb begin
        if (addr == DATA_ADDR)      sel = SEL_DATA;
        else if (addr == DIR_ADDR)  sel = SEL_DIR;
        else if (addr == OPT_ADDR)  sel = SEL_OPT;
        else                        sel = SEL_NONE;
    end

    assign wr_data = rst_n && we && (sel == SEL_DATA);
    assign wr_dir  = rst_n && we && (sel == SEL_DIR);
    assign wr_opt  = rst_n && we && (sel == SEL_OPT);

    // Data latch: loaded only by writes, deliberately untouched by reset
    always_ff @(posedge clk) begin
        if (wr_data) data_q <= wdata[W-1:0];
    end

    // Direction register: reset makes every pin an input
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata[W-1:0];
    end

    // Option register: pullup enable and LED mode, both cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
            led_q  <= 1'b0;
        end else if (wr_opt) begin
            pull_q <= wdata[PULL_BIT];
            led_q  <= wdata[LED_BIT];
        end
    end

    wire unused_wdata = ^wdata;

    // R1: reset clears all direction bits
    p_dir_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0))
        else $error("p_dir_reset_r1");

    // R2: a direction write lands on the next cycle
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wdata[W-1:0])))
        else $error("p_dir_write_r2");

    // R3: a data write lands regardless of direction
    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (data_q == $past(wdata[W-1:0])))
        else $error("p_data_write_r3");

    // R7: option write updates both controls
    p_opt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_opt |=> ((pull_q == $past(wdata[PULL_BIT])) && (led_q == $past(wdata[LED_BIT]))))
        else $error("p_opt_write_r7");
endmodule

// File: rtl/gpio5_pad_ctrl.sv
// Pad-side controls: output enable, output value and direction-gated pullups.
// Assumes the pad applies pin_out only while pin_oe is high.
module gpio5_pad_ctrl #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic         pull_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_pull_en
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            // Per-pin: drive the latch always, enable buffer and pullup by direction
            assign pin_oe[i]      = dir_q[i];
            assign pin_out[i]     = data_q[i];
            assign pin_pull_en[i] = pull_q & ~dir_q[i];
        end
    endgenerate
endmodule

// File: rtl/gpio5_readmux.sv
// Read-data multiplexer; unimplemented bits and unmapped addresses return zero.
// Assumes PULL_BIT and LED_BIT are distinct and below DW.
module gpio5_readmux
    import gpio5_pkg::*;
#(
    parameter int unsigned W        = 5,
    parameter int unsigned DW       = 8,
    parameter int unsigned PULL_BIT = 0,
    parameter int unsigned LED_BIT  = 1
) (
    input  reg_sel_e      sel,
    input  logic [W-1:0]  data_q,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  pin_sync,
    input  logic          pull_q,
    input  logic          led_q,
    output logic [DW-1:0] rdata
);
    // Select the register image for the addressed register
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DATA: rdata[W-1:0] = (dir_q & data_q) | (~dir_q & pin_sync);
            SEL_DIR:  rdata[W-1:0] = dir_q;
            SEL_OPT: begin
                rdata[PULL_BIT] = pull_q;
                rdata[LED_BIT]  = led_q;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio5_port.sv
// Top of the five-pin GPIO port: registers, input synchronizer, pad controls, read mux.
// Assumes a single clock with synchronous active-low reset.
module gpio5_port
    import gpio5_pkg::*;
#(
    parameter int unsigned W         = 5,
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 8,
    parameter logic [AW-1:0] DATA_ADDR = 'h02,
    parameter logic [AW-1:0] DIR_ADDR  = 'h06,
    parameter logic [AW-1:0] OPT_ADDR  = 'h0C,
    parameter int unsigned PULL_BIT  = 0,
    parameter int unsigned LED_BIT   = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_pull_en,
    output logic          led_mode
);
    reg_sel_e     sel;
    logic [W-1:0] data_q, dir_q, pin_sync;
    logic         pull_q, led_q;

    gpio5_regs #(
        .W(W), .AW(AW), .DW(DW),
        .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .OPT_ADDR(OPT_ADDR),
        .PULL_BIT(PULL_BIT), .LED_BIT(LED_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .sel(sel), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .led_q(led_q)
    );

    gpio5_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio5_pad_ctrl #(.W(W)) u_pad (
        .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull_en(pin_pull_en)
    );

    gpio5_readmux #(.W(W), .DW(DW), .PULL_BIT(PULL_BIT), .LED_BIT(LED_BIT)) u_rmux (
        .sel(sel), .data_q(data_q), .dir_q(dir_q), .pin_sync(pin_sync),
        .pull_q(pull_q), .led_q(led_q), .rdata(bus_rdata)
    );

    assign led_mode = led_q;
endmodule

// File: tb/tb_gpio5_port.sv
module tb_gpio5_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [4:0] pin_in = '0;
    logic [4:0] pin_out, pin_oe, pin_pull_en;
    logic       led_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio5_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pull_en(pin_pull_en), .led_mode(led_mode)
    );

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       we;
        logic [4:0] pins;
        logic [7:0] rd;
        logic [4:0] oe;
        logic [4:0] pull;
        logic [4:0] out;
        logic       led;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h02, 8'h15, 1'b1, 5'h0A, 8'h0A, 5'h00, 5'h00, 5'h15, 1'b0},
        '{8'h06, 8'hFF, 1'b1, 5'h0A, 8'h1F, 5'h1F, 5'h00, 5'h15, 1'b0},
        '{8'h02, 8'h00, 1'b0, 5'h0A, 8'h15, 5'h1F, 5'h00, 5'h15, 1'b0},
        '{8'h06, 8'h03, 1'b1, 5'h0C, 8'h03, 5'h03, 5'h00, 5'h15, 1'b0},
        '{8'h02, 8'h00, 1'b0, 5'h0C, 8'h0D, 5'h03, 5'h00, 5'h15, 1'b0},
        '{8'h0C, 8'hFF, 1'b1, 5'h0C, 8'h03, 5'h03, 5'h1C, 5'h15, 1'b1},
        '{8'h0C, 8'h01, 1'b1, 5'h0C, 8'h01, 5'h03, 5'h1C, 5'h15, 1'b0},
        '{8'h06, 8'h00, 1'b1, 5'h0C, 8'h00, 5'h00, 5'h1F, 5'h15, 1'b0},
        '{8'h07, 8'hFF, 1'b1, 5'h0C, 8'h00, 5'h00, 5'h1F, 5'h15, 1'b0},
        '{8'h02, 8'h0A, 1'b1, 5'h11, 8'h11, 5'h00, 5'h1F, 5'h0A, 1'b0},
        '{8'h06, 8'h1F, 1'b1, 5'h11, 8'h1F, 5'h1F, 5'h00, 5'h0A, 1'b0},
        '{8'h02, 8'h00, 1'b0, 5'h11, 8'h0A, 5'h1F, 5'h00, 5'h0A, 1'b0},
        '{8'h0C, 8'h00, 1'b1, 5'h11, 8'h00, 5'h1F, 5'h00, 5'h0A, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R7 / R8: reset state
        chk("R1 oe after reset", {3'b0, pin_oe}, 8'h00);
        chk("R7 pull after reset", {3'b0, pin_pull_en}, 8'h00);
        chk("R8 led after reset", {7'b0, led_mode}, 8'h00);
        rd_chk("R1 dir readback after reset", 8'h06, 8'h00);
        rd_chk("R7 option readback after reset", 8'h0C, 8'h00);

        // Vector table: R2 R3 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_in = VEC[i].pins;
            bus_addr = VEC[i].addr; bus_wdata = VEC[i].wdata; bus_we = VEC[i].we;
            @(negedge clk);
            bus_we = 1'b0;
            repeat (2) @(negedge clk);
            #1;
            chk($sformatf("R5/R2/R7/R9 rdata vec %0d", i), bus_rdata, VEC[i].rd);
            chk($sformatf("R2 oe vec %0d", i), {3'b0, pin_oe}, {3'b0, VEC[i].oe});
            chk($sformatf("R7 pull vec %0d", i), {3'b0, pin_pull_en}, {3'b0, VEC[i].pull});
            chk($sformatf("R3 out vec %0d", i), {3'b0, pin_out}, {3'b0, VEC[i].out});
            chk($sformatf("R8 led vec %0d", i), {7'b0, led_mode}, {7'b0, VEC[i].led});
        end

        // R6: two-edge input latency
        wr(8'h06, 8'h00);
        pin_in = 5'h00;
        repeat (3) @(negedge clk);
        bus_addr = 8'h02;
        pin_in = 5'h1F;
        @(negedge clk); #1;
        chk("R6 one edge after change", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R6 two edges after change", bus_rdata, 8'h1F);

        // R3: preload while input, then switch to output glitch-free
        wr(8'h02, 8'h13);
        #1;
        chk("R3 latch visible while input", {3'b0, pin_out}, 8'h13);
        chk("R3 buffer still off", {3'b0, pin_oe}, 8'h00);
        @(negedge clk);
        bus_addr = 8'h06; bus_wdata = 8'h1F; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        chk("R3 oe rises", {3'b0, pin_oe}, 8'h1F);
        chk("R3 preloaded value driven at switch", {3'b0, pin_out}, 8'h13);

        // R4 / R10: latch survives reset; writes during reset dropped
        wr(8'h0C, 8'h03);
        @(negedge clk);
        rst_n = 1'b0;
        bus_addr = 8'h02; bus_wdata = 8'h0C; bus_we = 1'b1;
        repeat (2) @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b1;
        #1;
        chk("R1 oe cleared by reset", {3'b0, pin_oe}, 8'h00);
        chk("R8 led cleared by reset", {7'b0, led_mode}, 8'h00);
        chk("R4 latch kept through reset", {3'b0, pin_out}, 8'h13);
        chk("R10 write during reset ignored", {3'b0, pin_out}, 8'h13);
        rd_chk("R7 option cleared by reset", 8'h0C, 8'h00);
        wr(8'h06, 8'h1F);
        rd_chk("R4 latch readback after reset", 8'h02, 8'h13);

        // R9: unmapped write leaves everything alone
        wr(8'h00, 8'hFF);
        rd_chk("R9 unmapped read", 8'h00, 8'h00);
        rd_chk("R9 dir unchanged", 8'h06, 8'h1F);
        rd_chk("R9 data unchanged", 8'h02, 8'h13);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule